// File: doc/BRIEF.md
# Microprogram Sequencer with OR-Branching

This block keeps the microprogram counter of a microcoded controller and produces the control-store address of the next microstep. The control store presents the current microword. Its next-address field gives the default successor. When the microword asks for a branch on a microtest, the successor is the next-address field with the condition bits of one decode group ORed into it. The decode groups are a general instruction decoder and a jump/subroutine-call detector. No address multiplexer is involved. When a decoder recognises nothing, it supplies zero. The successor is then the next-address field itself, which is how a fallback handler placed at a small address is reached.

A microword may also carry a clock-off flag, which marks that a bus read started earlier must finish before the following microstep runs. The step carrying the flag still executes and still loads its successor. After that the sequencer freezes, and it drops its microstep-enable strobe until the bus reports that the transfer is done. Two microroutines can share code because any step may name an arbitrary address in its next-address field.

Top module: `mseq_top`

## Requirements
- R1: On synchronous active-high reset the counter `mpc` is 0 and `step_en` is 1 in the first cycle after reset is released.
- R2: On an executing step (`step_en`=1) with `but_en`=0, the next `mpc` equals `nxt_field`, and the decode bits have no effect.
- R3: On an executing step with `but_en`=1, the next `mpc` equals `nxt_field` bitwise-ORed with the slice of `dec_bits` chosen by `grp_sel`. Group 0 (general decoder) occupies `dec_bits[7:0]`, and group 1 (jump/call detector) occupies `dec_bits[15:8]`.
- R4: A branch whose selected decode slice is all zero loads `nxt_field` unchanged. For example, `nxt_field`=1 leads to `mpc`=1.
- R5: A branch with `nxt_field`=8'o001 and a selected decode slice of 8'o204 gives `mpc`=8'o205.
- R6: With `grp_sel`=1, only the jump/call slice is ORed in, and the general slice is ignored. With `grp_sel`=0, only the general slice is ORed in.
- R7: An executing step with `clk_off`=1, sampled while `bus_done`=0, still loads its successor into `mpc`, and `step_en` is 0 from the next cycle.
- R8: While `step_en`=0, `mpc` holds and the microword inputs (`nxt_field`, `but_en`, `grp_sel`, `dec_bits`, `clk_off`) have no effect. `step_en` stays 0 while `bus_done` is sampled low.
- R9: While stalled, the first edge at which `bus_done` is sampled high makes `step_en` 1 in the next cycle, and sequencing then resumes from the held `mpc`.
- R10: An executing step with `clk_off`=1, sampled while `bus_done`=1, causes no stall, and `step_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nxt_field | input | 8 | Next-address field of the current microword |
| but_en | input | 1 | Branch-on-microtest request of the current microword |
| grp_sel | input | 1 | Decode group choice: 0 general, 1 jump/call |
| dec_bits | input | 16 | Condition bits of all decode groups, group g at bits [8g+7:8g] |
| clk_off | input | 1 | Stall after this step until the pending bus read finishes |
| bus_done | input | 1 | Pending bus transfer has completed, sampled on the clock edge |
| mpc | output | 8 | Microprogram counter (address of the current microword) |
| step_en | output | 1 | High when the current microword executes this cycle |

## Verification
Some rules are checked by the assertions on every cycle:
- a plain step loads the next-address field;
- every bit of the next-address field survives into the new counter value;
- the counter is frozen while the strobe is low;
- the strobe enters, holds and leaves the stall exactly as the clock-off flag and the done signal dictate.

Some rules can only be shown by the bench's scenarios, because they depend on specific values:
- the exact OR result, including the 001 | 204 = 205 octal case;
- the choice between the two decode groups;
- the empty-decode fallback;
- the reset value;
- resumption from the held address after a stall.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    // Default geometry of the sequencer
    localparam int unsigned ADDR_W_DEF  = 8;
    localparam int unsigned NUM_GRP_DEF = 2;

    // Sequencer run state
    typedef enum logic {
        SEQ_RUN  = 1'b0,
        SEQ_WAIT = 1'b1
    } seq_state_e;

    // Next state of the stall controller from the current state and inputs
    function automatic seq_state_e next_state(
        input seq_state_e cur,
        input logic       coff,
        input logic       done
    );
        seq_state_e ns;
        ns = cur;
        if (cur == SEQ_RUN) begin
            if (coff && !done) ns = SEQ_WAIT;
        end else begin
            if (done) ns = SEQ_RUN;
        end
        return ns;
    endfunction

endpackage

// File: rtl/mseq_next_addr.sv
module mseq_next_addr #(
    parameter int unsigned ADDR_W  = mseq_pkg::ADDR_W_DEF,
    parameter int unsigned NUM_GRP = mseq_pkg::NUM_GRP_DEF,
    localparam int unsigned GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic [ADDR_W-1:0]         nxt_field,
    input  logic                      but_en,
    input  logic [GSEL_W-1:0]         grp_sel,
    input  logic [NUM_GRP*ADDR_W-1:0] dec_bits,
    output logic [ADDR_W-1:0]         next_addr
);

    logic [ADDR_W-1:0] contrib [NUM_GRP];
    logic [ADDR_W-1:0] or_bits;

    // One gated contribution per decode group
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic hit;
        assign hit        = but_en && (grp_sel == GSEL_W'(g));
        assign contrib[g] = hit ? dec_bits[g*ADDR_W +: ADDR_W] : '0;
    end

    always_comb begin
        or_bits = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            or_bits = or_bits | contrib[g];
        end
    end

    assign next_addr = nxt_field | or_bits;

endmodule

// File: rtl/mseq_stall_ctl.sv
module mseq_stall_ctl (
    input  logic clk,
    input  logic rst,
    input  logic clk_off,
    input  logic bus_done,
    output logic step_en
);
    import mseq_pkg::*;

    seq_state_e state_q;
    seq_state_e state_d;

    always_comb begin
        state_d = next_state(state_q, clk_off, bus_done);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SEQ_RUN;
        else     state_q <= state_d;
    end

    assign step_en = (state_q == SEQ_RUN);

    // R7: executing clock-off step without done -> stall next cycle
    a_r7_enter_stall: assert property (@(posedge clk) disable iff (rst)
        (step_en && clk_off && !bus_done) |=> !step_en);

    // R10: done already present -> no stall
    a_r10_no_stall_when_done: assert property (@(posedge clk) disable iff (rst)
        (step_en && clk_off && bus_done) |=> step_en);

    // R9: done seen while stalled -> released next cycle
    a_r9_release: assert property (@(posedge clk) disable iff (rst)
        (!step_en && bus_done) |=> step_en);

    // R8: stall persists while done is low
    a_r8_hold_wait: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !bus_done) |=> !step_en);

endmodule

// File: rtl/mseq_top.sv
module mseq_top #(
    parameter int unsigned ADDR_W  = mseq_pkg::ADDR_W_DEF,
    parameter int unsigned NUM_GRP = mseq_pkg::NUM_GRP_DEF,
    localparam int unsigned GSEL_W = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         nxt_field,
    input  logic                      but_en,
    input  logic [GSEL_W-1:0]         grp_sel,
    input  logic [NUM_GRP*ADDR_W-1:0] dec_bits,
    input  logic                      clk_off,
    input  logic                      bus_done,
    output logic [ADDR_W-1:0]         mpc,
    output logic                      step_en
);

    logic [ADDR_W-1:0] next_addr;
    logic [ADDR_W-1:0] mpc_q;

    mseq_next_addr #(
        .ADDR_W  (ADDR_W),
        .NUM_GRP (NUM_GRP)
    ) u_next (
        .nxt_field (nxt_field),
        .but_en    (but_en),
        .grp_sel   (grp_sel),
        .dec_bits  (dec_bits),
        .next_addr (next_addr)
    );

    mseq_stall_ctl u_stall (
        .clk      (clk),
        .rst      (rst),
        .clk_off  (clk_off),
        .bus_done (bus_done),
        .step_en  (step_en)
    );

    // Counter advances only on an executing microstep
    always_ff @(posedge clk) begin
        if (rst)          mpc_q <= '0;
        else if (step_en) mpc_q <= next_addr;
    end

    assign mpc = mpc_q;

    // R8: counter frozen while stalled
    a_r8_mpc_frozen: assert property (@(posedge clk) disable iff (rst)
        !step_en |=> $stable(mpc));

    // R2: plain step loads the next-address field
    a_r2_plain_step: assert property (@(posedge clk) disable iff (rst)
        (step_en && !but_en) |=> (mpc == $past(nxt_field)));

    // R3: every next-address bit survives into the new counter
    a_r3_nxt_bits_kept: assert property (@(posedge clk) disable iff (rst)
        step_en |=> ((mpc & $past(nxt_field)) == $past(nxt_field)));

endmodule

// File: tb/tb_mseq_top.sv
module tb_mseq_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  nxt_field;
    logic        but_en;
    logic [0:0]  grp_sel;
    logic [15:0] dec_bits;
    logic        clk_off;
    logic        bus_done;
    logic [7:0]  mpc;
    logic        step_en;

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] exp_mpc;
    logic       exp_stall;

    always #(CLK_P/2) clk = ~clk;

    mseq_top dut (
        .clk       (clk),
        .rst       (rst),
        .nxt_field (nxt_field),
        .but_en    (but_en),
        .grp_sel   (grp_sel),
        .dec_bits  (dec_bits),
        .clk_off   (clk_off),
        .bus_done  (bus_done),
        .mpc       (mpc),
        .step_en   (step_en)
    );

    task automatic check(input string tag, input string what,
                         input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Called at a negedge: drive, clock, compare at the following negedge
    task automatic do_step(input string tag, input logic [7:0] nx, input logic be,
                           input logic gs, input logic [7:0] gen, input logic [7:0] jmp,
                           input logic co, input logic dn);
        nxt_field = nx; but_en = be; grp_sel = gs;
        dec_bits = {jmp, gen}; clk_off = co; bus_done = dn;
        if (!exp_stall) begin
            exp_mpc = be ? (nx | (gs ? jmp : gen)) : nx;
            if (co && !dn) exp_stall = 1'b1;
        end else if (dn) begin
            exp_stall = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check(tag, "mpc", mpc, exp_mpc);
        check(tag, "step_en", {7'd0, step_en}, {7'd0, !exp_stall});
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; nxt_field = 8'hFF; but_en = 1'b1; grp_sel = 1'b0;
        dec_bits = 16'hFFFF; clk_off = 1'b1; bus_done = 1'b0;
        exp_mpc = 8'd0; exp_stall = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        check("R1", "mpc", mpc, 8'd0);
        check("R1", "step_en", {7'd0, step_en}, 8'd1);

        // R2: plain steps over every address, decode bits must not matter
        for (int i = 0; i < 256; i++)
            do_step("R2", 8'(i), 1'b0, 1'(i), 8'(i * 73 + 5), 8'(i * 29 + 3), 1'b0, 1'b0);

        // R3: branch with the general group over every address
        for (int i = 0; i < 256; i++)
            do_step("R3", 8'(i), 1'b1, 1'b0, 8'(i * 73 + 5), 8'(i * 29 + 3), 1'b0, 1'b0);

        // R6: branch with the jump/call group, general slice ignored
        for (int i = 0; i < 256; i++)
            do_step("R6", 8'(i * 5), 1'b1, 1'b1, 8'hFF, 8'(i), 1'b0, 1'b0);
        do_step("R6", 8'h10, 1'b1, 1'b0, 8'h02, 8'hC0, 1'b0, 1'b0);

        // R4: nothing recognised -> fallback at 1
        do_step("R4", 8'd1, 1'b1, 1'b0, 8'd0, 8'hAA, 1'b0, 1'b0);
        check("R4", "fallback", mpc, 8'd1);

        // R5: 001 | 204 octal = 205 octal
        do_step("R5", 8'o001, 1'b1, 1'b0, 8'o204, 8'd0, 1'b0, 1'b0);
        check("R5", "octal example", mpc, 8'o205);

        // R7: clock-off step without done -> successor loaded, then stall
        do_step("R7", 8'h40, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b0);
        check("R7", "stalled", {7'd0, step_en}, 8'd0);

        // R8: held microword, garbage inputs, done low
        for (int k = 0; k < 6; k++)
            do_step("R8", 8'(k * 37 + 1), 1'(k), 1'(k >> 1), 8'hFF, 8'h5A, 1'(k), 1'b0);
        check("R8", "mpc held", mpc, 8'h40);

        // R9: done releases, then sequencing resumes
        do_step("R9", 8'h77, 1'b1, 1'b1, 8'h0F, 8'hF0, 1'b1, 1'b1);
        check("R9", "released", {7'd0, step_en}, 8'd1);
        check("R9", "held addr", mpc, 8'h40);
        do_step("R9", 8'h22, 1'b1, 1'b0, 8'h01, 8'h00, 1'b0, 1'b0);
        check("R9", "resumed", mpc, 8'h23);

        // R10: clock-off with done already high -> no stall
        do_step("R10", 8'h31, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b1);
        do_step("R10", 8'h32, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0);

        // Shared code: unconditional jump back into an earlier routine
        do_step("R2", 8'o205, 1'b0, 1'b0, 8'd0, 8'd0, 1'b0, 1'b0);

        // R1: reset during a stall returns to address 0 and running
        do_step("R7", 8'h55, 1'b0, 1'b0, 8'd0, 8'd0, 1'b1, 1'b0);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        exp_mpc = 8'd0; exp_stall = 1'b0;
        check("R1", "mpc after reset", mpc, 8'd0);
        check("R1", "step_en after reset", {7'd0, step_en}, 8'd1);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule